// File: doc/BRIEF.md
# Two-Channel CIC Decimation Front End

This block reduces the sample rate of two parallel signed sample streams by a programmable integer ratio. It uses a cascaded integrator-comb structure. Each channel accepts one sample per clock and shifts it left by a programmable number of bit positions. The sample then passes through four integrators running at the input rate. Four comb sections, clocked at the output rate with a differential delay of one, take over from there. Both channels share the ratio and the shift setting, and they deliver their results on the same clock under one valid strobe.

Software configures the block through a byte-wide write port. The ratio is written as the ratio minus one, as an 11-bit value split across two byte addresses. A third address holds the pre-shift count. A new ratio does not disturb the output period already in progress. It is adopted at the next output boundary, where the phase counter starts over.

Top module: `cic_decim_top`

## Requirements
- R1: After reset, `dout_vld_o` is low, both data outputs are zero, the decimation setting is 7 (ratio 8) and the shift setting is 0.
- R2: A byte written with `reg_we_i` high goes to one of three addresses. Address 0 loads bits 7:0 of the decimation setting. Address 1 loads bits 10:8 from data bits 2:0, and data bits 7:3 are ignored. Address 2 loads the 6-bit shift setting from data bits 5:0. Writes to any other address change nothing.
- R3: With a decimation setting D, the ratio is N = D + 1. `dout_vld_o` is high for exactly one clock in every N clocks, for N up to 2048.
- R4: A decimation setting below 7 gives a ratio of 8.
- R5: A change to the decimation setting takes effect only at the next output boundary. The period in progress completes at the old ratio, and the counter restarts from zero at the boundary.
- R6: Each input sample is shifted left by the shift setting before the first integrator. A shift setting above 40 acts as 40.
- R7: A constant input x, held long enough, gives an output of x·2^S·N^4. Here S is the effective shift. The arithmetic is two's complement and wraps, and the accumulator width is input width + 40 + 44 bits.
- R8: Both channels use the same ratio, shift and strobe, and each channel filters its own input independently.
- R9: Each data output holds its value between strobes, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one input sample per channel per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| din_a_i | input | IN_W (12) | Channel A signed input sample |
| din_b_i | input | IN_W (12) | Channel B signed input sample |
| dout_a_o | output | ACC_W (96) | Channel A decimated signed output |
| dout_b_o | output | ACC_W (96) | Channel B decimated signed output |
| dout_vld_o | output | 1 | One-clock strobe marking a new output on both channels |

## Verification
The hardest case to reach is a ratio write that lands in the middle of an output period. The bench first waits for a strobe, which puts it at a known phase. It then writes the new ratio two cycles later and counts clocks to the following strobe. That gap must still equal the old ratio, and only the gap after it may equal the new one. The extreme corner is a ratio of 2048 combined with a shift of 40, because the accumulator then nearly fills. For this case the bench holds constant inputs of both signs for several full periods and compares the settled output against the closed-form gain.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned DEC_W       = 11;
  localparam int unsigned SCALE_W     = 6;
  localparam int unsigned MAX_SHIFT   = 40;
  localparam int unsigned MIN_DEC     = 7;
  localparam int unsigned RATIO_W     = DEC_W + 1;
  localparam logic [7:0]  ADDR_DEC_LO = 8'h00;
  localparam logic [7:0]  ADDR_DEC_HI = 8'h01;
  localparam logic [7:0]  ADDR_SCALE  = 8'h02;
endpackage

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [DEC_W-1:0]   dec_o,
  output logic [SCALE_W-1:0] shift_o
);
  logic [DEC_W-1:0]   dec_q;
  logic [SCALE_W-1:0] scale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= DEC_W'(MIN_DEC);
      scale_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_DEC_LO: dec_q[7:0]       <= wdata_i;
        ADDR_DEC_HI: dec_q[DEC_W-1:8] <= wdata_i[DEC_W-9:0];
        ADDR_SCALE:  scale_q          <= wdata_i[SCALE_W-1:0];
        default: ;
      endcase
    end
  end

  assign dec_o   = dec_q;
  // out-of-range shift saturates
  assign shift_o = (scale_q > SCALE_W'(MAX_SHIFT)) ? SCALE_W'(MAX_SHIFT) : scale_q;

  assert_dec_hi_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DEC_HI) |=> dec_q[DEC_W-1:8] == $past(wdata_i[DEC_W-9:0]));
endmodule

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr
  import cic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEC_W-1:0] dec_i,
  output logic             tick_o
);
  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(MIN_DEC + 1);

  logic [RATIO_W-1:0] ratio_q, ratio_next, cnt_q;

  assign ratio_next = (dec_i < DEC_W'(MIN_DEC)) ? MIN_RATIO : RATIO_W'(dec_i) + 1'b1;
  assign tick_o     = (cnt_q == ratio_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= MIN_RATIO;
    end else if (tick_o) begin
      cnt_q   <= '0;
      ratio_q <= ratio_next;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  assert_ratio_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= MIN_RATIO);
  assert_ratio_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(ratio_q));
endmodule

// File: rtl/cic_chan.sv
module cic_chan #(
  parameter int unsigned IN_W    = 12,
  parameter int unsigned ACC_W   = 96,
  parameter int unsigned STAGES  = 4,
  parameter int unsigned SHIFT_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  din_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    tick_i,
  output logic signed [ACC_W-1:0] dout_o
);
  logic signed [ACC_W-1:0] x_ext, x_sh;
  logic signed [ACC_W-1:0] integ_q [STAGES];
  logic signed [ACC_W-1:0] comb_d  [STAGES+1];
  logic signed [ACC_W-1:0] dly_q   [STAGES];
  logic signed [ACC_W-1:0] dout_q;

  assign x_ext = ACC_W'(din_i);
  assign x_sh  = x_ext <<< shift_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_integ
    logic signed [ACC_W-1:0] feed;
    if (s == 0) begin : g_first
      assign feed = x_sh;
    end else begin : g_rest
      assign feed = integ_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) integ_q[s] <= '0;
      else         integ_q[s] <= integ_q[s] + feed;
    end
  end

  assign comb_d[0] = integ_q[STAGES-1];

  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    assign comb_d[s+1] = comb_d[s] - dly_q[s];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q[s] <= '0;
      else if (tick_i) dly_q[s] <= comb_d[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_q <= '0;
    else if (tick_i) dout_q <= comb_d[STAGES];
  end

  assign dout_o = dout_q;

  assert_hold_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(dout_q));
endmodule

// File: rtl/cic_decim_top.sv
module cic_decim_top
  import cic_pkg::*;
#(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned STAGES = 4,
  localparam int unsigned ACC_W = IN_W + MAX_SHIFT + STAGES * DEC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [7:0]              reg_addr_i,
  input  logic [7:0]              reg_wdata_i,
  input  logic signed [IN_W-1:0]  din_a_i,
  input  logic signed [IN_W-1:0]  din_b_i,
  output logic signed [ACC_W-1:0] dout_a_o,
  output logic signed [ACC_W-1:0] dout_b_o,
  output logic                    dout_vld_o
);
  logic [DEC_W-1:0]   dec;
  logic [SCALE_W-1:0] shift;
  logic               tick;
  logic               vld_q;

  cic_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .dec_o   (dec),
    .shift_o (shift)
  );

  cic_rate_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec),
    .tick_o (tick)
  );

  cic_chan #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES), .SHIFT_W(SCALE_W)) u_chan_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din_a_i),
    .shift_i (shift),
    .tick_i  (tick),
    .dout_o  (dout_a_o)
  );

  cic_chan #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES), .SHIFT_W(SCALE_W)) u_chan_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din_b_i),
    .shift_i (shift),
    .tick_i  (tick),
    .dout_o  (dout_b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= tick;
  end

  assign dout_vld_o = vld_q;

  assert_vld_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_vld_o |=> !dout_vld_o);
endmodule

// File: tb/cic_decim_top_tb_top.sv
module cic_decim_top_tb_top;
  localparam int IN_W  = 12;
  localparam int ACC_W = 96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic signed [IN_W-1:0] din_a_i = '0;
  logic signed [IN_W-1:0] din_b_i = '0;
  logic signed [ACC_W-1:0] dout_a_o, dout_b_o;
  logic dout_vld_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  cic_decim_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .din_a_i(din_a_i), .din_b_i(din_b_i),
    .dout_a_o(dout_a_o), .dout_b_o(dout_b_o), .dout_vld_o(dout_vld_o)
  );

  function automatic logic signed [ACC_W-1:0] dc_exp(int x, int sh, int r);
    logic signed [ACC_W-1:0] v;
    v = ACC_W'(x);
    v = v <<< sh;
    v = v * r * r * r * r;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic signed [ACC_W-1:0] act,
                       input logic signed [ACC_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wait_vld();
    do @(negedge clk_i); while (!dout_vld_o);
  endtask

  task automatic settle(input int n);
    repeat (n) wait_vld();
  endtask

  task automatic gap(output int g);
    wait_vld();
    g = 0;
    do begin @(negedge clk_i); g++; end while (!dout_vld_o);
  endtask

  task automatic t_reset();
    int g;
    check(dout_vld_o == 1'b0, "R1 vld", ACC_W'(dout_vld_o), 0);
    check(dout_a_o == 0 && dout_b_o == 0, "R1 data", dout_a_o | dout_b_o, 0);
    gap(g);
    check(g == 8, "R1 default ratio", g, 8);
  endtask

  task automatic t_dc();
    din_a_i = 12'sd5; din_b_i = -12'sd7;
    settle(12);
    check(dout_a_o == dc_exp(5, 0, 8), "R7 dc gain A", dout_a_o, dc_exp(5, 0, 8));
    check(dout_b_o == dc_exp(-7, 0, 8), "R8 channel B independent", dout_b_o, dc_exp(-7, 0, 8));
  endtask

  task automatic t_hold();
    logic signed [ACC_W-1:0] cap;
    wait_vld();
    cap = dout_a_o;
    din_a_i = 12'sd100;
    repeat (5) @(negedge clk_i);
    check(dout_a_o == cap, "R9 hold between strobes", dout_a_o, cap);
    din_a_i = 12'sd5;
    settle(12);
  endtask

  task automatic t_ratio();
    int g;
    do_write(8'h00, 8'd15);
    do_write(8'h01, 8'hF8);  // upper bits ignored, R2
    settle(2);
    gap(g);
    check(g == 16, "R3 ratio DEC+1, R2 high bits ignored", g, 16);
    settle(10);
    check(dout_a_o == dc_exp(5, 0, 16), "R7 dc gain ratio 16", dout_a_o, dc_exp(5, 0, 16));
    do_write(8'h01, 8'h01);
    settle(2);
    gap(g);
    check(g == 272, "R2 high byte of DEC", g, 272);
    do_write(8'h01, 8'h00);
    settle(2);
  endtask

  task automatic t_clamp();
    int g;
    do_write(8'h00, 8'd3);
    settle(2);
    gap(g);
    check(g == 8, "R4 clamp DEC=3", g, 8);
    do_write(8'h00, 8'd0);
    settle(2);
    gap(g);
    check(g == 8, "R4 clamp DEC=0", g, 8);
  endtask

  task automatic t_boundary();
    int g;
    wait_vld();
    do_write(8'h00, 8'd31);
    g = 2;
    do begin @(negedge clk_i); g++; end while (!dout_vld_o);
    check(g == 8, "R5 period in progress keeps old ratio", g, 8);
    g = 0;
    do begin @(negedge clk_i); g++; end while (!dout_vld_o);
    check(g == 32, "R5 new ratio after boundary", g, 32);
  endtask

  task automatic t_scale();
    do_write(8'h00, 8'd7);
    do_write(8'h02, 8'd3);
    din_a_i = 12'sd1;
    settle(14);
    check(dout_a_o == dc_exp(1, 3, 8), "R6 preshift 3", dout_a_o, dc_exp(1, 3, 8));
    do_write(8'h02, 8'd63);
    settle(14);
    check(dout_a_o == dc_exp(1, 40, 8), "R6 shift saturates at 40", dout_a_o, dc_exp(1, 40, 8));
  endtask

  task automatic t_other_addr();
    int g;
    do_write(8'h03, 8'hFF);
    do_write(8'h82, 8'h00);
    settle(2);
    gap(g);
    check(g == 8, "R2 other address leaves ratio", g, 8);
    check(dout_a_o == dc_exp(1, 40, 8), "R2 other address leaves shift", dout_a_o, dc_exp(1, 40, 8));
  endtask

  task automatic t_max();
    int g;
    do_write(8'h00, 8'hFF);
    do_write(8'h01, 8'h07);
    do_write(8'h02, 8'd40);
    din_a_i = -12'sd3; din_b_i = 12'sd2047;
    settle(8);
    gap(g);
    check(g == 2048, "R3 ratio 2048", g, 2048);
    check(dout_a_o == dc_exp(-3, 40, 2048), "R7 full-scale A", dout_a_o, dc_exp(-3, 40, 2048));
    check(dout_b_o == dc_exp(2047, 40, 2048), "R8 full-scale B", dout_b_o, dc_exp(2047, 40, 2048));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_dc();
    t_hold();
    t_ratio();
    t_clamp();
    t_boundary();
    t_scale();
    t_other_addr();
    t_max();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule